// File: doc/BRIEF.md
# Chip-select window address decoder

This block maps a 32-bit system address onto one of eight external device regions. Each region is described by one window word. The word holds a 6-bit base, a 4-bit size mask and an enable bit. Software writes and reads these words through a small 32-bit register port. The decode side takes an address every cycle. One cycle later it presents a one-hot chip select, a hit flag, the byte offset inside the selected window, a decode-error flag and an overlap flag.

A window is `2^(28 - popcount(mask))` bytes long. It starts at `base * 2^24`. Only four masks are legal. The base must be aligned to the window size. A word that breaks either rule makes its region decode nothing, and no error is raised for it. Configuration is accepted only as full 32-bit accesses. A narrower access is turned away and leaves a sticky error flag set.

Top module: `cs_window_decoder`

## Requirements
- R1: The window word of chip select n is at register offset 0x078 + 0x30*n. Its layout is base in bits 5:0, enable in bit 6 and mask in bits 11:8. Writes keep only the bits under 0xF7F, and all other bits read as zero. Read data appears on `reg_rdata` one cycle after the read request.
- R2: After reset every window word has mask 0xF and base 0. Chip select 0 is enabled (word 0xF40) and chip selects 1 to 7 are disabled (word 0xF00). An address below 16 MB therefore selects chip select 0.
- R3: Reading offset 0x014 returns 1. Any other offset that is not a window word reads zero, and writes to it change nothing.
- R4: A region with its enable bit clear never matches.
- R5: A region whose mask is not 0x8, 0xC, 0xE or 0xF never matches.
- R6: A region whose base is not a multiple of its window size in 16 MB units never matches.
- R7: A legal, enabled region matches exactly the addresses from `base*2^24` up to, but not including, `base*2^24 + 2^(28-popcount(mask))`. The sizes are 128, 64, 32 and 16 MB for masks 0x8, 0xC, 0xE and 0xF. An address with bit 31 or bit 30 set never matches.
- R8: On a hit, `cs_offset` equals the address minus the start of the winning window.
- R9: The decode outputs are registered one cycle after `dec_addr`. `cs_sel` is zero or one-hot, and `cs_hit` is the inverse of `dec_err`. On a miss, `cs_sel` and `cs_offset` are zero. During reset all decode outputs are zero.
- R10: When several regions match, the lowest-numbered one is selected and `dec_overlap` is 1. With a single match, `dec_overlap` is 0.
- R11: An access with any byte enable low has the following effects. A write changes no register. A read returns zero. `bad_width_err` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables; all four must be set |
| reg_rdata | output | 32 | Registered read data |
| bad_width_err | output | 1 | Sticky narrow-access flag |
| dec_addr | input | 32 | System address to decode |
| cs_sel | output | 8 | One-hot chip select |
| cs_hit | output | 1 | Address fell in a region |
| cs_offset | output | 28 | Offset inside the selected window |
| dec_err | output | 1 | No region matched |
| dec_overlap | output | 1 | More than one region matched |

## Verification
A single chip select is swept over all 16 mask values, all 64 bases and both enable states. Each setting is probed at the window start, the last byte, one past the end, one below the start, and the start with the top address bits set. The probes at both edges and just outside them separate a correct size from an off-by-one or a wrong mask polarity. The sweep also separates illegal-mask, misaligned-base and disabled regions from legal ones. Separate patterns cover the reset map, the status and reserved offsets, write masking, narrow accesses, and two regions claiming the same address, which exercises priority and the overlap flag.

// File: rtl/cswd_pkg.sv
package cswd_pkg;
  localparam int SYS_AW = 32;
  localparam int OFS_W  = 28;
  localparam logic [31:0] WIN_WR_MASK = 32'h0000_0F7F;

  typedef struct packed {
    logic [3:0] mask;
    logic       valid;
    logic [5:0] base;
  } cs_win_t;

  function automatic logic mask_ok(logic [3:0] m);
    return (m == 4'h8) || (m == 4'hC) || (m == 4'hE) || (m == 4'hF);
  endfunction

  // usable = enabled, legal mask, base aligned to window size
  function automatic logic win_usable(cs_win_t w);
    return w.valid && mask_ok(w.mask) && ((w.base[3:0] & ~w.mask) == 4'h0);
  endfunction

  function automatic logic [31:0] win_to_word(cs_win_t w);
    return {20'h0, w.mask, 1'b0, w.valid, w.base};
  endfunction
endpackage

// File: rtl/cswd_regs.sv
module cswd_regs
  import cswd_pkg::*;
#(
  parameter int NUM_CS   = 8,
  parameter int RA_W     = 12,
  parameter int BANK0    = 'h060,
  parameter int STRIDE   = 'h030,
  parameter int WIN_OFS  = 'h018,
  parameter int STAT_OFS = 'h014
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   we,
  input  logic [RA_W-1:0]        addr,
  input  logic [31:0]            wdata,
  input  logic [3:0]             be,
  output logic [31:0]            rdata,
  output logic                   bad_width,
  output cs_win_t [NUM_CS-1:0]   win
);
  localparam cs_win_t RST_ON  = '{mask: 4'hF, valid: 1'b1, base: 6'h00};
  localparam cs_win_t RST_OFF = '{mask: 4'hF, valid: 1'b0, base: 6'h00};

  cs_win_t           win_q [NUM_CS];
  logic [NUM_CS-1:0] hit_bank;
  logic              full_w;
  logic              wr_ok;
  cs_win_t           new_win;
  logic [31:0]       rd_mux;
  logic              unused_wbits;

  assign full_w  = &be;
  assign wr_ok   = en && we && full_w;
  assign new_win = '{mask: wdata[11:8], valid: wdata[6], base: wdata[5:0]};
  assign unused_wbits = ^{wdata[31:12], wdata[7]};

  for (genvar i = 0; i < NUM_CS; i++) begin : g_bank
    assign hit_bank[i] = (addr == RA_W'(BANK0 + i * STRIDE + WIN_OFS));
    assign win[i]      = win_q[i];
    always_ff @(posedge clk) begin
      if (rst) win_q[i] <= (i == 0) ? RST_ON : RST_OFF;
      else if (wr_ok && hit_bank[i]) win_q[i] <= new_win;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == RA_W'(STAT_OFS)) rd_mux = 32'd1;
    for (int i = 0; i < NUM_CS; i++)
      if (hit_bank[i]) rd_mux = win_to_word(win_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      bad_width <= 1'b0;
    end else begin
      if (en && !we) rdata <= full_w ? rd_mux : 32'd0;
      if (en && !full_w) bad_width <= 1'b1;
    end
  end

  AST_STATUS_ONE: assert property (@(posedge clk) disable iff (rst)
    (en && !we && full_w && addr == RA_W'(STAT_OFS)) |=> (rdata == 32'd1)); // R3
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en && !we) |=> ((rdata & ~WIN_WR_MASK) == 32'd0)); // R1
  AST_NARROW_KEEP: assert property (@(posedge clk) disable iff (rst)
    (en && we && !full_w) |=> $stable(win)); // R11
  AST_NARROW_FLAG: assert property (@(posedge clk) disable iff (rst)
    (en && !full_w) |=> bad_width); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    bad_width |=> bad_width); // R11
endmodule

// File: rtl/cswd_match.sv
module cswd_match
  import cswd_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input  cs_win_t [NUM_CS-1:0] win,
  input  logic [SYS_AW-1:0]    addr,
  output logic [NUM_CS-1:0]    match
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
    assign match[i] = win_usable(win[i])
                   && (addr[31:30] == 2'b00)
                   && (addr[29:28] == win[i].base[5:4])
                   && (((addr[27:24] ^ win[i].base[3:0]) & win[i].mask) == 4'h0);
  end
endmodule

// File: rtl/cswd_pick.sv
module cswd_pick
  import cswd_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CS-1:0]      match,
  input  logic [NUM_CS-1:0][3:0] masks,
  input  logic [OFS_W-1:0]       addr_lo,
  output logic [NUM_CS-1:0]      cs_sel,
  output logic                   hit,
  output logic [OFS_W-1:0]       offset,
  output logic                   err,
  output logic                   overlap
);
  logic [NUM_CS-1:0] first_oh;
  logic [3:0]        sel_mask;
  logic              any_m;
  logic              multi;
  logic [OFS_W-1:0]  off_n;

  always_comb begin
    first_oh = match & (~match + NUM_CS'(1));
    any_m    = |match;
    multi    = (match & (match - NUM_CS'(1))) != '0;
    sel_mask = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (first_oh[i]) sel_mask = masks[i];
    off_n = any_m ? (addr_lo & ~{sel_mask, {(OFS_W-4){1'b0}}}) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sel  <= '0;
      hit     <= 1'b0;
      offset  <= '0;
      err     <= 1'b0;
      overlap <= 1'b0;
    end else begin
      cs_sel  <= first_oh;
      hit     <= any_m;
      offset  <= off_n;
      err     <= !any_m;
      overlap <= multi;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_sel)); // R9
  AST_HIT_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hit != err)); // R9
  AST_HIT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hit == $past(|match))); // R9
  AST_OVERLAP_HIT: assert property (@(posedge clk) disable iff (rst)
    overlap |-> hit); // R10
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cswd_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int RA_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [3:0]        reg_be,
  output logic [31:0]       reg_rdata,
  output logic              bad_width_err,
  input  logic [31:0]       dec_addr,
  output logic [NUM_CS-1:0] cs_sel,
  output logic              cs_hit,
  output logic [27:0]       cs_offset,
  output logic              dec_err,
  output logic              dec_overlap
);
  cs_win_t [NUM_CS-1:0]   win;
  logic [NUM_CS-1:0]      match;
  logic [NUM_CS-1:0][3:0] masks;

  cswd_regs #(.NUM_CS(NUM_CS), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst(rst), .en(reg_en), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .be(reg_be), .rdata(reg_rdata),
    .bad_width(bad_width_err), .win(win)
  );

  cswd_match #(.NUM_CS(NUM_CS)) u_match (
    .win(win), .addr(dec_addr), .match(match)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_mask
    assign masks[i] = win[i].mask;
  end

  cswd_pick #(.NUM_CS(NUM_CS)) u_pick (
    .clk(clk), .rst(rst), .match(match), .masks(masks),
    .addr_lo(dec_addr[OFS_W-1:0]), .cs_sel(cs_sel), .hit(cs_hit),
    .offset(cs_offset), .err(dec_err), .overlap(dec_overlap)
  );
endmodule

// File: tb/sim_cs_window_decoder.sv
module sim_cs_window_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_en, reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [3:0]  reg_be;
  logic [31:0] reg_rdata;
  logic        bad_width_err;
  logic [31:0] dec_addr;
  logic [7:0]  cs_sel;
  logic        cs_hit, dec_err, dec_overlap;
  logic [27:0] cs_offset;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  cs_window_decoder u0 (
    .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
    .bad_width_err(bad_width_err), .dec_addr(dec_addr), .cs_sel(cs_sel),
    .cs_hit(cs_hit), .cs_offset(cs_offset), .dec_err(dec_err),
    .dec_overlap(dec_overlap)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] wofs(input int cs);
    return 12'(12'h078 + cs * 12'h030);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a; reg_be = be;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  // returns {sel[7:0], hit, err, overlap, offset[27:0]}
  task automatic dec(input logic [31:0] a, output logic [38:0] r);
    @(negedge clk);
    dec_addr = a;
    @(negedge clk);
    r = {cs_sel, cs_hit, dec_err, dec_overlap, cs_offset};
  endtask

  function automatic int pc4(input logic [3:0] m);
    return int'(m[0]) + int'(m[1]) + int'(m[2]) + int'(m[3]);
  endfunction

  task automatic sweep_one(input logic v, input logic [3:0] m, input logic [5:0] b);
    longint start, size, a;
    logic legal, aligned;
    logic [38:0] r, e;
    string tag;
    longint probes [5];
    start   = longint'(b) * 64'h100_0000;
    size    = 64'd1 << (28 - ((m == 4'h0) ? 4 : pc4(m)));
    legal   = (m == 4'h8) || (m == 4'hC) || (m == 4'hE) || (m == 4'hF);
    aligned = (start % size) == 0;
    if (!v) tag = "R4";
    else if (!legal) tag = "R5";
    else if (!aligned) tag = "R6";
    else tag = "R7";
    wr(wofs(5), {20'h0, m, 1'b0, v, b}, 4'hF);
    probes[0] = start;
    probes[1] = start + size - 1;
    probes[2] = start + size;
    probes[3] = (start > 0) ? start - 1 : 64'd0;
    probes[4] = start | 64'hC000_0000;
    foreach (probes[k]) begin
      a = probes[k];
      dec(a[31:0], r);
      if (v && legal && aligned && a >= start && a < start + size && a < 64'h4000_0000)
        e = {8'h20, 1'b1, 1'b0, 1'b0, 28'(a - start)};
      else
        e = {8'h00, 1'b0, 1'b1, 1'b0, 28'h0};
      chk(tag, {25'h0, r[38:28]}, {25'h0, e[38:28]});
      if (e[36]) chk("R8", {36'h0, r[27:0]}, {36'h0, e[27:0]});
      else chk("R9", {36'h0, r[27:0]}, 64'h0);
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [38:0] r;
    rst = 1'b1; reg_en = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; reg_be = 4'hF;
    dec_addr = 32'h0000_1234;
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", {52'h0, cs_sel, cs_hit, dec_err, dec_overlap, bad_width_err}, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < 8; i++) begin
      rd(wofs(i), 4'hF, d);
      chk("R2 reset word", {32'h0, d}, (i == 0) ? 64'hF40 : 64'hF00);
    end
    dec(32'h00AB_CDEF, r);
    chk("R2 reset decode", {25'h0, r}, {25'h0, 8'h01, 1'b1, 1'b0, 1'b0, 28'h0AB_CDEF});
    dec(32'h0100_0000, r);
    chk("R2 reset miss", {25'h0, r}, {25'h0, 8'h00, 1'b0, 1'b1, 1'b0, 28'h0});

    rd(12'h014, 4'hF, d);
    chk("R3 status", {32'h0, d}, 64'h1);
    wr(12'h070, 32'hFFFF_FFFF, 4'hF);
    rd(12'h070, 4'hF, d);
    chk("R3 reserved", {32'h0, d}, 64'h0);

    wr(wofs(3), 32'hFFFF_FFFF, 4'hF);
    rd(wofs(3), 4'hF, d);
    chk("R1 write mask", {32'h0, d}, 64'hF7F);

    chk("R11 flag clear", {63'h0, bad_width_err}, 64'h0);
    wr(wofs(3), 32'h0, 4'h3);
    chk("R11 flag set", {63'h0, bad_width_err}, 64'h1);
    rd(wofs(3), 4'hF, d);
    chk("R11 write ignored", {32'h0, d}, 64'hF7F);
    rd(wofs(3), 4'h1, d);
    chk("R11 narrow read", {32'h0, d}, 64'h0);
    repeat (3) @(negedge clk);
    chk("R11 sticky", {63'h0, bad_width_err}, 64'h1);

    // R10: two regions on the same 16 MB window at 0x1000_0000
    wr(wofs(0), 32'h0, 4'hF);
    wr(wofs(1), 32'hF50, 4'hF);
    wr(wofs(3), 32'hF50, 4'hF);
    dec(32'h1000_0010, r);
    chk("R10 priority", {25'h0, r}, {25'h0, 8'h02, 1'b1, 1'b0, 1'b1, 28'h10});
    wr(wofs(1), 32'h0, 4'hF);
    dec(32'h1000_0010, r);
    chk("R10 single", {25'h0, r}, {25'h0, 8'h08, 1'b1, 1'b0, 1'b0, 28'h10});
    wr(wofs(3), 32'h0, 4'hF);

    for (int v = 0; v < 2; v++)
      for (int m = 0; m < 16; m++)
        for (int b = 0; b < 64; b++)
          sweep_one(v[0], m[3:0], b[5:0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule